// File: doc/BRIEF.md
# Character Panel Row Scan Sequencer

This block drives the time-multiplexed rows of a dot-matrix character panel. It walks one common line at a time through a scan whose length depends on the display geometry. A single text line in the short font uses eight commons. A single line in the tall font uses eleven. Two text lines use sixteen. Each common stays selected for one row slot. Early in the slot the block asks an external font source for the dot row of each of the eight visible characters, one character at a time. It sends the forty resulting segment bits out serially, two clocks per bit, and then captures them in parallel onto the segment outputs.

The block also produces the polarity-alternation signal that keeps the panel drive free of DC. The serial shift clock, latch strobe and data tap let further column drivers be chained behind it. It overlays an underline cursor or a blinking block on the character at the cursor address. It forces all segments dark when the display is disabled. Glyph storage and analog drive levels sit outside: the font source answers the combinational `fetch_addr`/`fetch_row` request on `row_dots`.

Top module: `lcd_scan_seq`

## Requirements
- R1: Exactly one bit of `com_out` is high at any time, and bit k means common k. Commons advance by one at each slot boundary and wrap to 0 after the last common. Eight commons are used for one line in the short font (`two_line`=0, `tall_font`=0), eleven for one line in the tall font (`tall_font`=1), and sixteen whenever `two_line`=1, whatever `tall_font` is. Reset selects common 0.
- R2: A row slot lasts `ROW_LONG` clocks for the 8- and 11-common scans and `ROW_SHORT` clocks for the 16-common scan.
- R3: Segment 5c+d shows bit (4-d) of `row_dots`, so bit 4 is the leftmost dot, for character c (0..7). That character is fetched at `fetch_addr` = c in one-line mode. In two-line mode it is c on commons 0..7 and 64+c on commons 8..15. `fetch_row` is the common number in one-line mode and the common modulo 8 in two-line mode.
- R4: Each slot issues exactly 40 `ext_shift` pulses. Each bit takes two clocks with the pulse on the second. `ext_latch` is a one-clock pulse in the clock after the last shift. `seg_out` changes only in the clock after an `ext_latch` pulse.
- R5: `ext_data` is the bit leaving the far end of the shift chain. Between a latch and the next slot's first shift it equals segment 0 of the row just latched.
- R6: By default `m_out` toggles once per frame, when the scan wraps to common 0. With `A_TYPE`=1 it toggles at every slot boundary. It is 0 after reset.
- R7: With `cursor_en`=1, the character whose fetch address equals `cursor_addr` shows all five dots on its cursor row. The cursor row is 7 in the short font and in two-line mode, and 10 for the tall font in one-line mode.
- R8: A blink phase starts at 0 after reset and flips every `BLINK_FRAMES` frames. With `blink_en`=1, during phase 1 the character at `cursor_addr` shows all dots on every row. During phase 0 it shows its normal pattern, plus the cursor row if R7 applies.
- R9: While `disp_on`=0, every latched segment and `ext_data` are 0, and the commons keep scanning.
- R10: During reset `com_out`=1, `seg_out`=0, `m_out`=0, and `ext_shift` and `ext_latch` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| two_line | input | 1 | 1 selects two text lines (16 commons) |
| tall_font | input | 1 | 1 selects the 11-row font in one-line mode |
| disp_on | input | 1 | 0 blanks all segments |
| cursor_en | input | 1 | Underline cursor enable |
| blink_en | input | 1 | Blinking block cursor enable |
| cursor_addr | input | 7 | Display address carrying the cursor |
| row_dots | input | DOT_W | Dot row returned by the font source |
| fetch_addr | output | 7 | Display address of the character being fetched |
| fetch_row | output | 4 | Glyph row being fetched |
| com_out | output | NCOM_MAX | One-hot common select |
| seg_out | output | NUM_CHARS*DOT_W | Latched segment data |
| m_out | output | 1 | Drive polarity alternation |
| ext_shift | output | 1 | Serial shift strobe for chained drivers |
| ext_latch | output | 1 | Parallel latch strobe |
| ext_data | output | 1 | Serial data leaving the shift chain |

## Verification
The bench attacks the geometry switches. It runs eleven-common scans, which would expose a scan that wraps at a power of two. It runs two-line scans with `tall_font` held high, which would expose a design that lets the font bit leak into the 16-common duty or the short slot length. It places the cursor on the last row of each font and on a second-line address, where an off-by-one row or a missing line offset would draw the underline in the wrong place. It also counts frames across two blink periods and follows the polarity signal of both drive variants. A design that flipped polarity per slot instead of per frame, or flipped blink on the wrong frame, would mismatch within a few slots. Bit ordering through the serial chain is checked against segment 0 at the tap, which catches a reversed shift direction.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

   typedef enum logic [1:0] {
      DUTY_8  = 2'd0,
      DUTY_11 = 2'd1,
      DUTY_16 = 2'd2
   } duty_e;

   function automatic duty_e pick_duty(input logic two_line, input logic tall_font);
      if (two_line)       return DUTY_16;
      else if (tall_font) return DUTY_11;
      else                return DUTY_8;
   endfunction

endpackage

// File: rtl/scan_timer.sv
module scan_timer
   import lcd_scan_pkg::*;
#(
   parameter int ROW_LONG     = 400,
   parameter int ROW_SHORT    = 200,
   parameter int NCOM_ONE     = 8,
   parameter int NCOM_TALL    = 11,
   parameter int NCOM_MAX     = 16,
   parameter int BLINK_FRAMES = 32,
   parameter bit A_TYPE       = 1'b0,
   localparam int CNT_W       = $clog2(ROW_LONG + 1),
   localparam int COM_W       = $clog2(NCOM_MAX),
   localparam int BLK_W       = $clog2(BLINK_FRAMES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  duty_e            duty,
   output logic [CNT_W-1:0] slot_cnt,
   output logic [COM_W-1:0] com_idx,
   output logic             m,
   output logic             blink_ph
);

   logic [CNT_W-1:0] slot_len;
   logic [COM_W-1:0] last_com;
   logic [BLK_W-1:0] frame_cnt;
   logic             slot_end;
   logic             frame_end;

   always_comb begin
      case (duty)
         DUTY_16: begin
            slot_len = CNT_W'(ROW_SHORT);
            last_com = COM_W'(NCOM_MAX - 1);
         end
         DUTY_11: begin
            slot_len = CNT_W'(ROW_LONG);
            last_com = COM_W'(NCOM_TALL - 1);
         end
         default: begin
            slot_len = CNT_W'(ROW_LONG);
            last_com = COM_W'(NCOM_ONE - 1);
         end
      endcase
   end

   // a shortened slot after a mode change still ends at once
   assign slot_end  = (slot_cnt >= slot_len - 1'b1);
   assign frame_end = slot_end && (com_idx >= last_com);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_cnt <= '0;
         com_idx  <= '0;
      end else if (slot_end) begin
         slot_cnt <= '0;
         com_idx  <= (com_idx >= last_com) ? '0 : com_idx + 1'b1;
      end else begin
         slot_cnt <= slot_cnt + 1'b1;
      end
   end

   generate
      if (A_TYPE) begin : g_pol_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        m <= 1'b0;
            else if (slot_end) m <= ~m;
         end
      end else begin : g_pol_frame
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         m <= 1'b0;
            else if (frame_end) m <= ~m;
         end
         // R6
         m_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (m != $past(m)) |-> (com_idx == '0));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_cnt <= '0;
         blink_ph  <= 1'b0;
      end else if (frame_end) begin
         if (frame_cnt == BLK_W'(BLINK_FRAMES - 1)) begin
            frame_cnt <= '0;
            blink_ph  <= ~blink_ph;
         end else begin
            frame_cnt <= frame_cnt + 1'b1;
         end
      end
   end

   // R6
   m_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m != $past(m)) |-> (slot_cnt == '0));

   // R1
   com_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (com_idx != $past(com_idx)) |->
         (slot_cnt == '0 && (com_idx == '0 || com_idx == $past(com_idx) + 1'b1)));

endmodule

// File: rtl/seg_shifter.sv
module seg_shifter #(
   parameter int SEG_W       = 40,
   parameter int CNT_W       = 9,
   localparam int SHIFT_CLKS = 2 * SEG_W,
   localparam int IDX_W      = $clog2(SEG_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] slot_cnt,
   input  logic             bit_in,
   output logic [IDX_W-1:0] bit_idx,
   output logic [SEG_W-1:0] seg_lat,
   output logic             ext_shift,
   output logic             ext_latch,
   output logic             ext_data
);

   logic [SEG_W-1:0] sreg;
   logic             active;

   assign active    = (slot_cnt < CNT_W'(SHIFT_CLKS));
   assign bit_idx   = IDX_W'(slot_cnt >> 1);
   assign ext_shift = active & slot_cnt[0];
   assign ext_latch = (slot_cnt == CNT_W'(SHIFT_CLKS));
   assign ext_data  = sreg[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sreg <= '0;
      else if (ext_shift) sreg <= {bit_in, sreg[SEG_W-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         seg_lat <= '0;
      else if (ext_latch) seg_lat <= sreg;
   end

   // R4
   latch_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_latch |-> $past(ext_shift));

   // R4
   seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ext_latch) |-> $stable(seg_lat));

endmodule

// File: rtl/dot_overlay.sv
module dot_overlay #(
   parameter int DOT_W = 5
) (
   input  logic [DOT_W-1:0] dots_i,
   input  logic             hit,
   input  logic             cur_line,
   input  logic             cursor_en,
   input  logic             blink_en,
   input  logic             blink_ph,
   input  logic             disp_on,
   output logic [DOT_W-1:0] dots_o
);

   logic [DOT_W-1:0] shown;

   always_comb begin
      shown = dots_i;
      if (hit && blink_en && blink_ph)       shown = '1;
      else if (hit && cursor_en && cur_line) shown = '1;
      dots_o = disp_on ? shown : '0;
   end

endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq
   import lcd_scan_pkg::*;
#(
   parameter int NUM_CHARS    = 8,
   parameter int DOT_W        = 5,
   parameter int ADDR_W       = 7,
   parameter int LINE2_BASE   = 64,
   parameter int NCOM_ONE     = 8,
   parameter int NCOM_TALL    = 11,
   parameter int NCOM_MAX     = 16,
   parameter int ROW_LONG     = 400,
   parameter int ROW_SHORT    = 200,
   parameter int BLINK_FRAMES = 32,
   parameter bit A_TYPE       = 1'b0,
   localparam int SEG_W       = NUM_CHARS * DOT_W,
   localparam int ROW_W       = $clog2(NCOM_TALL)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                two_line,
   input  logic                tall_font,
   input  logic                disp_on,
   input  logic                cursor_en,
   input  logic                blink_en,
   input  logic [ADDR_W-1:0]   cursor_addr,
   input  logic [DOT_W-1:0]    row_dots,
   output logic [ADDR_W-1:0]   fetch_addr,
   output logic [ROW_W-1:0]    fetch_row,
   output logic [NCOM_MAX-1:0] com_out,
   output logic [SEG_W-1:0]    seg_out,
   output logic                m_out,
   output logic                ext_shift,
   output logic                ext_latch,
   output logic                ext_data
);

   localparam int CNT_W  = $clog2(ROW_LONG + 1);
   localparam int COM_W  = $clog2(NCOM_MAX);
   localparam int IDX_W  = $clog2(SEG_W + 1);
   localparam int CHR_W  = $clog2(NUM_CHARS);
   localparam int DOT_IW = $clog2(DOT_W);

   initial begin : param_chk
      assert (ROW_SHORT > 2 * SEG_W) else $error("row slot too short for the shift phase");
      assert (ROW_LONG >= ROW_SHORT) else $error("long slot must not be shorter than short slot");
      assert (NCOM_MAX == 2 * NCOM_ONE) else $error("two-line scan must double the line commons");
      assert (NCOM_TALL > NCOM_ONE && NCOM_TALL <= NCOM_MAX) else $error("tall font commons out of range");
      assert (BLINK_FRAMES >= 2) else $error("blink period must be at least two frames");
      assert (NUM_CHARS <= LINE2_BASE) else $error("visible characters overlap the second line");
   end

   duty_e            duty;
   logic [CNT_W-1:0] slot_cnt;
   logic [COM_W-1:0] com_idx;
   logic             blink_ph;
   logic [IDX_W-1:0] bit_idx;
   logic [CHR_W-1:0] char_i;
   logic [DOT_IW-1:0] dot_i;
   logic             line_sel;
   logic [ROW_W-1:0] cur_row;
   logic [DOT_W-1:0] ov_dots;
   logic             bit_in;

   assign duty = pick_duty(two_line, tall_font);

   scan_timer #(
      .ROW_LONG(ROW_LONG), .ROW_SHORT(ROW_SHORT), .NCOM_ONE(NCOM_ONE),
      .NCOM_TALL(NCOM_TALL), .NCOM_MAX(NCOM_MAX),
      .BLINK_FRAMES(BLINK_FRAMES), .A_TYPE(A_TYPE)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .duty(duty), .slot_cnt(slot_cnt),
      .com_idx(com_idx), .m(m_out), .blink_ph(blink_ph)
   );

   seg_shifter #(.SEG_W(SEG_W), .CNT_W(CNT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .slot_cnt(slot_cnt), .bit_in(bit_in),
      .bit_idx(bit_idx), .seg_lat(seg_out), .ext_shift(ext_shift),
      .ext_latch(ext_latch), .ext_data(ext_data)
   );

   assign char_i     = CHR_W'(bit_idx / IDX_W'(DOT_W));
   assign dot_i      = DOT_IW'(bit_idx % IDX_W'(DOT_W));
   assign line_sel   = two_line && (com_idx >= COM_W'(NCOM_ONE));
   assign fetch_row  = two_line ? ROW_W'(com_idx % COM_W'(NCOM_ONE)) : ROW_W'(com_idx);
   assign fetch_addr = (line_sel ? ADDR_W'(LINE2_BASE) : '0) + ADDR_W'(char_i);
   assign cur_row    = (tall_font && !two_line) ? ROW_W'(NCOM_TALL - 1) : ROW_W'(NCOM_ONE - 1);

   dot_overlay #(.DOT_W(DOT_W)) u_overlay (
      .dots_i(row_dots), .hit(cursor_addr == fetch_addr),
      .cur_line(fetch_row == cur_row), .cursor_en(cursor_en),
      .blink_en(blink_en), .blink_ph(blink_ph), .disp_on(disp_on),
      .dots_o(ov_dots)
   );

   assign bit_in = ov_dots[DOT_IW'(DOT_W - 1) - dot_i];

   generate
      for (genvar g = 0; g < NCOM_MAX; g++) begin : g_com
         assign com_out[g] = (com_idx == COM_W'(g));
      end
   endgenerate

   // R1
   com_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(com_out) == 1);

endmodule

// File: tb/sim_lcd_scan_seq.sv
`timescale 1ns/1ps
module sim_lcd_scan_seq;

   localparam int LONG  = 120;
   localparam int SHORT = 100;
   localparam int BLK   = 2;
   localparam int SEGS  = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        two_line = 1'b0, tall_font = 1'b0, disp_on = 1'b1;
   logic        cursor_en = 1'b0, blink_en = 1'b0;
   logic [6:0]  cursor_addr = 7'h7f;
   logic [4:0]  row_dots;
   logic [6:0]  fetch_addr, fetch_addr_a;
   logic [3:0]  fetch_row, fetch_row_a;
   logic [15:0] com_out, com_a;
   logic [39:0] seg_out, seg_a;
   logic        m_out, m_a, ext_shift, ext_latch, ext_data;
   logic        sh_a, lt_a, dt_a;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   function automatic logic [4:0] font(input logic [6:0] a, input logic [3:0] r);
      logic [7:0] t;
      t = {1'b0, a} * 8'd7 + {4'b0, r} * 8'd5 + 8'd3;
      return t[4:0] ^ 5'h0a;
   endfunction

   assign row_dots = font(fetch_addr, fetch_row);

   lcd_scan_seq #(.ROW_LONG(LONG), .ROW_SHORT(SHORT), .BLINK_FRAMES(BLK)) u0 (
      .clk(clk), .rst_n(rst_n), .two_line(two_line), .tall_font(tall_font),
      .disp_on(disp_on), .cursor_en(cursor_en), .blink_en(blink_en),
      .cursor_addr(cursor_addr), .row_dots(row_dots), .fetch_addr(fetch_addr),
      .fetch_row(fetch_row), .com_out(com_out), .seg_out(seg_out), .m_out(m_out),
      .ext_shift(ext_shift), .ext_latch(ext_latch), .ext_data(ext_data)
   );

   lcd_scan_seq #(.ROW_LONG(LONG), .ROW_SHORT(SHORT), .BLINK_FRAMES(BLK), .A_TYPE(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .two_line(two_line), .tall_font(tall_font),
      .disp_on(disp_on), .cursor_en(cursor_en), .blink_en(blink_en),
      .cursor_addr(cursor_addr), .row_dots(row_dots), .fetch_addr(fetch_addr_a),
      .fetch_row(fetch_row_a), .com_out(com_a), .seg_out(seg_a), .m_out(m_a),
      .ext_shift(sh_a), .ext_latch(lt_a), .ext_data(dt_a)
   );

   task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [39:0] exp_segs(input int com, input int ph);
      logic [39:0] r;
      int row, line, crow;
      r    = '0;
      row  = two_line ? com % 8 : com;
      line = two_line ? com / 8 : 0;
      crow = (tall_font && !two_line) ? 10 : 7;
      for (int c = 0; c < 8; c++) begin
         logic [6:0] a;
         logic [4:0] dt;
         a  = 7'(line * 64 + c);
         dt = font(a, 4'(row));
         if (a == cursor_addr && blink_en && ph == 1)            dt = '1;
         else if (a == cursor_addr && cursor_en && row == crow)  dt = '1;
         if (!disp_on) dt = '0;
         for (int d = 0; d < 5; d++) r[c*5 + d] = dt[4 - d];
      end
      return r;
   endfunction

   task automatic apply_cfg(input logic tl, input logic tf, input logic d,
                            input logic ce, input logic be, input logic [6:0] ca);
      @(negedge clk);
      rst_n = 1'b0;
      two_line = tl; tall_font = tf; disp_on = d;
      cursor_en = ce; blink_en = be; cursor_addr = ca;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_slots(input int n, input string tag);
      int ncom, period;
      ncom   = two_line ? 16 : (tall_font ? 11 : 8);
      period = two_line ? SHORT : LONG;
      for (int s = 0; s < n; s++) begin
         int cyc, shf, com, frame, ph;
         logic [39:0] e;
         cyc = (s == 0) ? 0 : 1;
         shf = 0;
         do begin
            @(negedge clk);
            cyc++;
            if (ext_shift) shf++;
         end while (!ext_latch);
         if (s > 0) chk(cyc == period, "R2 slot length", 64'(cyc), 64'(period));
         chk(shf == SEGS, "R4 shift pulses", 64'(shf), 64'(SEGS));
         @(negedge clk);
         com   = s % ncom;
         frame = s / ncom;
         ph    = (frame / BLK) % 2;
         e     = exp_segs(com, ph);
         chk(com_out == 16'(1 << com), "R1 common select", 64'(com_out), 64'(1 << com));
         chk(seg_out == e, tag, 64'(seg_out), 64'(e));
         chk(ext_latch == 1'b0, "R4 latch pulse width", 64'(ext_latch), 64'(0));
         chk(ext_data == e[0], "R5 chain tap", 64'(ext_data), 64'(e[0]));
         chk(m_out == 1'(frame % 2), "R6 frame polarity", 64'(m_out), 64'(frame % 2));
         chk(m_a == 1'(s % 2), "R6 slot polarity", 64'(m_a), 64'(s % 2));
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(com_out == 16'h0001, "R10 reset common", 64'(com_out), 64'h1);
      chk(seg_out == '0, "R10 reset segments", 64'(seg_out), 64'h0);
      chk(m_out == 1'b0, "R10 reset polarity", 64'(m_out), 64'h0);
      chk(ext_shift == 1'b0 && ext_latch == 1'b0, "R10 reset strobes",
          64'({ext_shift, ext_latch}), 64'h0);
   endtask

   task automatic t_one_line_short;
      apply_cfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 7'h7f);
      run_slots(16, "R3 short font rows");
   endtask

   task automatic t_one_line_tall;
      apply_cfg(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 7'h7f);
      run_slots(22, "R3 tall font rows");
   endtask

   task automatic t_two_line;
      apply_cfg(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 7'h7f);
      run_slots(32, "R3 two line rows");
   endtask

   task automatic t_dark;
      apply_cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 7'h02);
      run_slots(8, "R9 display off");
   endtask

   task automatic t_cursor;
      apply_cfg(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 7'h03);
      run_slots(8, "R7 cursor short font");
      apply_cfg(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 7'h07);
      run_slots(11, "R7 cursor tall font");
      apply_cfg(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 7'h42);
      run_slots(16, "R7 cursor second line");
   endtask

   task automatic t_blink;
      apply_cfg(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 7'h05);
      run_slots(32, "R8 blink phases");
   endtask

   initial begin
      t_reset();
      t_one_line_short();
      t_one_line_tall();
      t_two_line();
      t_dark();
      t_cursor();
      t_blink();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule